// File: doc/BRIEF.md
# Clear-To-Send Modem Status and Transmit Gating

This block keeps the modem status byte of a serial port for a single modem input, the active-low Clear To Send line. The pin is brought into the clock domain through a flop chain. The block reports the asserted sense of the line in the status byte and keeps a sticky flag that records any change of that sense. A read strobe from the CPU clears the flag, and an enable bit turns the flag into a modem status interrupt. In internal loopback the reported line is taken from the Request To Send control bit rather than from the pin.

When automatic flow control is switched on, the same observed value gates the transmitter through a permit output. Releasing the line never cuts off a character that is already being sent. The permit falls only while the transmitter reports a character boundary, and it returns one clock after the line is asserted again.

Three state machines do the work. The tracker moves from FILL to LIVE once the synchronizer holds a real pin sample. The change flag moves from CLEAR to PENDING when a change is seen in LIVE, and back to CLEAR on a read with no change in that cycle. The transmit gate has three states and these transitions:
- SEND goes to HALT when a stop is requested at a boundary, and to DRAIN when a stop is requested in the middle of a character.
- DRAIN goes to HALT at the next boundary, and back to SEND if the stop request goes away.
- HALT goes back to SEND when the stop request goes away.

A stop is requested when flow control is on, the tracker is in LIVE, and status bit 4 reads 0.

Top module: `mdm_cts_status`

## Requirements
- R1: Outside loopback, status bit 4 equals the inverse of `cts_n_pin`, after a two-flop synchronizer and a status register. A pin change is visible on the third rising edge after it.
- R2: With `mcr_loop` high, status bit 4 equals `mcr_rts` one clock later.
- R3: Status bit 0 becomes 1 on the edge where status bit 4 changes value in LIVE. It keeps that value until an edge where `msr_read` is high. The byte read in that cycle still shows the flag.
- R4: `msi_irq` is high exactly when status bit 0 is 1 and `msi_enable` is high.
- R5: Status bits 7:5 and 3:1 always read 0.
- R6: With `mcr_afc` high and status bit 4 at 0, `tx_permit` stays high while `tx_char_boundary` is low. It falls only on an edge where `tx_char_boundary` is high.
- R7: With `mcr_afc` low, `tx_permit` is high one clock later. When status bit 4 returns to 1, `tx_permit` is high one clock later, from either DRAIN or HALT.
- R8: During reset the status byte is 0x00, `msi_irq` is low and `tx_permit` is high.
- R9: If a change and a read fall on the same edge, status bit 0 ends up 1.
- R10: For the first three edges after reset, status bit 4 loads without setting status bit 0. A pin held low through reset therefore shows bit 4 = 1 and bit 0 = 0.
- R11: Switching `mcr_loop` sets status bit 0 when the looped value differs from the pin value, and does not set it when the two are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_pin | input | 1 | Clear To Send pin, low = asserted |
| mcr_rts | input | 1 | Request To Send control bit |
| mcr_loop | input | 1 | Internal loopback enable |
| mcr_afc | input | 1 | Automatic CTS flow control enable |
| msi_enable | input | 1 | Modem status interrupt enable |
| msr_read | input | 1 | One-cycle read strobe of the status byte |
| tx_char_boundary | input | 1 | High while the transmitter sits between characters |
| msr_value | output | 8 | Status byte: bit 4 line state, bit 0 change flag |
| msi_irq | output | 1 | Modem status interrupt |
| tx_permit | output | 1 | Transmitter may load a new start bit |

## Verification
Two events can land on the same clock edge: a change that sets the flag and a CPU read that clears it. The bench provokes this by changing the pin and then raising the read strobe exactly two clocks later, so the read meets the edge where the synchronized value flips. The flag must read 1 afterwards. The second collision is a stop request arriving while a character is in flight. The bench holds the boundary input low for several clocks and expects the permit to stay high, then raises the boundary and expects the permit to fall on that edge. A behavioural model, run in parallel, judges every cycle of a long randomized run as well.

// File: rtl/mdm_cts_pkg.sv
package mdm_cts_pkg;

    localparam int MSR_W        = 8;
    localparam int BIT_LINE     = 4;
    localparam int BIT_DELTA    = 0;

    typedef enum logic {
        TRK_FILL,
        TRK_LIVE
    } trk_state_e;

    typedef enum logic {
        FLG_CLEAR,
        FLG_PENDING
    } flag_state_e;

    typedef enum logic [1:0] {
        FC_SEND,
        FC_DRAIN,
        FC_HALT
    } fc_state_e;

endpackage

// File: rtl/mdm_sync_chain.sv
module mdm_sync_chain #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= RESET_VAL;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= RESET_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/mdm_delta_tracker.sv
module mdm_delta_tracker
    import mdm_cts_pkg::*;
#(
    parameter int FILL_EDGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic obs_in,
    input  logic rd_strobe,
    output logic obs_q,
    output logic delta_flag,
    output logic live
);

    localparam int CW = $clog2(FILL_EDGES + 1);

    trk_state_e  trk_state, trk_next;
    flag_state_e flg_state, flg_next;
    logic [CW-1:0] fill_cnt, fill_next;
    logic change_seen;

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_state <= TRK_FILL;
            flg_state <= FLG_CLEAR;
            fill_cnt  <= '0;
            obs_q     <= 1'b0;
        end else begin
            trk_state <= trk_next;
            flg_state <= flg_next;
            fill_cnt  <= fill_next;
            obs_q     <= obs_in;
        end
    end

    assign change_seen = (trk_state == TRK_LIVE) && (obs_in != obs_q);

    // next-state process
    always_comb begin
        trk_next  = trk_state;
        fill_next = fill_cnt;
        unique case (trk_state)
            TRK_FILL: begin
                if (fill_cnt == CW'(FILL_EDGES - 1)) trk_next = TRK_LIVE;
                else                                 fill_next = fill_cnt + 1'b1;
            end
            TRK_LIVE: trk_next = TRK_LIVE;
            default:  trk_next = TRK_FILL;
        endcase

        flg_next = flg_state;
        unique case (flg_state)
            FLG_CLEAR: begin
                if (change_seen) flg_next = FLG_PENDING;
            end
            FLG_PENDING: begin
                if (!change_seen && rd_strobe) flg_next = FLG_CLEAR;
            end
            default: flg_next = FLG_CLEAR;
        endcase
    end

    // output process
    always_comb begin
        delta_flag = (flg_state == FLG_PENDING);
        live       = (trk_state == TRK_LIVE);
    end

endmodule

// File: rtl/mdm_flow_gate.sv
module mdm_flow_gate
    import mdm_cts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic afc_en,
    input  logic line_ok,
    input  logic live,
    input  logic boundary,
    output logic permit
);

    fc_state_e fc_state, fc_next;
    logic stop_req;

    assign stop_req = afc_en && live && !line_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fc_state <= FC_SEND;
        else        fc_state <= fc_next;
    end

    always_comb begin
        fc_next = fc_state;
        unique case (fc_state)
            FC_SEND: begin
                if (stop_req) fc_next = boundary ? FC_HALT : FC_DRAIN;
            end
            FC_DRAIN: begin
                if (!stop_req)     fc_next = FC_SEND;
                else if (boundary) fc_next = FC_HALT;
            end
            FC_HALT: begin
                if (!stop_req) fc_next = FC_SEND;
            end
            default: fc_next = FC_SEND;
        endcase
    end

    always_comb begin
        permit = (fc_state != FC_HALT);
    end

endmodule

// File: rtl/mdm_cts_status.sv
module mdm_cts_status
    import mdm_cts_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cts_n_pin,
    input  logic             mcr_rts,
    input  logic             mcr_loop,
    input  logic             mcr_afc,
    input  logic             msi_enable,
    input  logic             msr_read,
    input  logic             tx_char_boundary,
    output logic [MSR_W-1:0] msr_value,
    output logic             msi_irq,
    output logic             tx_permit
);

    localparam int FILL_EDGES = SYNC_STAGES + 1;

    logic cts_n_sync;
    logic line_sel;
    logic line_q;
    logic delta_flag;
    logic trk_live;

    mdm_sync_chain #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cts_n_pin),
        .q_sync  (cts_n_sync)
    );

    // asserted sense of the line: pin inverted, or RTS in loopback
    assign line_sel = mcr_loop ? mcr_rts : ~cts_n_sync;

    mdm_delta_tracker #(
        .FILL_EDGES (FILL_EDGES)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .obs_in     (line_sel),
        .rd_strobe  (msr_read),
        .obs_q      (line_q),
        .delta_flag (delta_flag),
        .live       (trk_live)
    );

    mdm_flow_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .afc_en   (mcr_afc),
        .line_ok  (line_q),
        .live     (trk_live),
        .boundary (tx_char_boundary),
        .permit   (tx_permit)
    );

    always_comb begin
        msr_value            = '0;
        msr_value[BIT_LINE]  = line_q;
        msr_value[BIT_DELTA] = delta_flag;
        msi_irq              = delta_flag && msi_enable;
    end

endmodule

// File: rtl/mdm_cts_checker.sv
module mdm_cts_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] msr_value,
    input logic       msi_irq,
    input logic       msi_enable,
    input logic       mcr_loop,
    input logic       mcr_rts,
    input logic       mcr_afc,
    input logic       tx_permit,
    input logic       tx_char_boundary,
    input logic       live
);

    p_loop_follows_rts_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mcr_loop)) |-> (msr_value[4] == $past(mcr_rts)));

    p_change_sets_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(live) && (msr_value[4] != $past(msr_value[4])))
        |-> msr_value[0]);

    p_irq_from_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_value[0] && msi_enable) |-> msi_irq);

    p_halt_at_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(tx_permit)) |-> $past(tx_char_boundary));

    p_no_halt_without_afc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mcr_afc)) |-> tx_permit);

endmodule

bind mdm_cts_status mdm_cts_checker u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .msr_value        (msr_value),
    .msi_irq          (msi_irq),
    .msi_enable       (msi_enable),
    .mcr_loop         (mcr_loop),
    .mcr_rts          (mcr_rts),
    .mcr_afc          (mcr_afc),
    .tx_permit        (tx_permit),
    .tx_char_boundary (tx_char_boundary),
    .live             (trk_live)
);

// File: tb/mdm_cts_status_tb.sv
`timescale 1ns/1ps
module mdm_cts_status_tb_top;

    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_n_pin = 1'b0;
    logic       mcr_rts = 1'b0;
    logic       mcr_loop = 1'b0;
    logic       mcr_afc = 1'b0;
    logic       msi_enable = 1'b0;
    logic       msr_read = 1'b0;
    logic       tx_char_boundary = 1'b1;
    logic [7:0] msr_value;
    logic       msi_irq;
    logic       tx_permit;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mdm_cts_status #(.SYNC_STAGES(SYNC)) dut_i (
        .clk (clk), .rst_n (rst_n), .cts_n_pin (cts_n_pin),
        .mcr_rts (mcr_rts), .mcr_loop (mcr_loop), .mcr_afc (mcr_afc),
        .msi_enable (msi_enable), .msr_read (msr_read),
        .tx_char_boundary (tx_char_boundary), .msr_value (msr_value),
        .msi_irq (msi_irq), .tx_permit (tx_permit)
    );

    // behavioural reference model
    bit m_sync[$] = '{1'b1, 1'b1};
    bit m_line = 0;
    bit m_flag = 0;
    int m_edges = 0;
    int m_gate = 0;   // 0 sending, 1 draining, 2 halted

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sync = '{1'b1, 1'b1};
            m_line = 0; m_flag = 0; m_edges = 0; m_gate = 0;
        end else begin
            bit ready;
            bit stop;
            bit nline;
            ready = (m_edges >= SYNC + 1);
            stop  = mcr_afc && ready && !m_line;
            if (!stop)                         m_gate = 0;
            else if (tx_char_boundary)         m_gate = 2;
            else if (m_gate == 0)              m_gate = 1;
            nline = mcr_loop ? mcr_rts : !m_sync[SYNC-1];
            if (ready && nline != m_line) m_flag = 1;
            else if (msr_read)            m_flag = 0;
            m_line = nline;
            m_sync.push_front(cts_n_pin);
            void'(m_sync.pop_back());
            if (m_edges < 1000) m_edges++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [7:0] e;
        e = {3'b000, m_line, 3'b000, m_flag};
        chk(msr_value[4] === e[4], mcr_loop ? "R2 line bit" : "R1 line bit", msr_value[4], e[4]);
        chk(msr_value[0] === e[0], "R3 change flag", msr_value[0], e[0]);
        chk({msr_value[7:5], msr_value[3:1]} === 6'b0, "R5 reserved bits", msr_value, e);
        chk(msi_irq === (m_flag && msi_enable), "R4 interrupt", msi_irq, m_flag && msi_enable);
        chk(tx_permit === (m_gate != 2), "R6 R7 permit", tx_permit, m_gate != 2);
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic clear_flag();
        msr_read = 1'b1; step(); msr_read = 1'b0; step();
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R8: reset values
        repeat (3) @(negedge clk);
        chk(msr_value === 8'h00, "R8 reset status", msr_value, 0);
        chk(msi_irq === 1'b0, "R8 reset irq", msi_irq, 0);
        chk(tx_permit === 1'b1, "R8 reset permit", tx_permit, 1);
        rst_n = 1'b1;
        msi_enable = 1'b1;
        // R10: pin held low (asserted) through reset, no flag
        step(5);
        chk(msr_value[4] === 1'b1, "R10 line after fill", msr_value[4], 1);
        chk(msr_value[0] === 1'b0, "R10 no flag after fill", msr_value[0], 0);

        // R1/R3/R4: pin released, flag and interrupt after three edges
        cts_n_pin = 1'b1;
        step(2);
        chk(msr_value[4] === 1'b1, "R1 not yet visible", msr_value[4], 1);
        step();
        chk(msr_value[4] === 1'b0, "R1 visible on third edge", msr_value[4], 0);
        chk(msr_value[0] === 1'b1, "R3 flag set", msr_value[0], 1);
        chk(msi_irq === 1'b1, "R4 irq raised", msi_irq, 1);
        msi_enable = 1'b0; step();
        chk(msi_irq === 1'b0, "R4 irq masked", msi_irq, 0);
        msr_read = 1'b1; step();
        msr_read = 1'b0;
        chk(msr_value[0] === 1'b0, "R3 cleared by read", msr_value[0], 0);
        step(2);

        // R9: change and read on the same edge
        cts_n_pin = 1'b0;
        step(2);
        msr_read = 1'b1; step();
        msr_read = 1'b0;
        chk(msr_value[0] === 1'b1, "R9 set wins over read", msr_value[0], 1);
        clear_flag();

        // R2/R11: loopback with RTS equal to pin sense (no change), then differing
        mcr_rts = 1'b1; mcr_loop = 1'b1; step(3);
        chk(msr_value[0] === 1'b0, "R11 equal value no flag", msr_value[0], 0);
        mcr_rts = 1'b0; step();
        chk(msr_value[4] === 1'b0, "R2 follows rts", msr_value[4], 0);
        chk(msr_value[0] === 1'b1, "R11 looped change flagged", msr_value[0], 1);
        clear_flag();
        mcr_loop = 1'b0; step();
        chk(msr_value[0] === 1'b1, "R11 leaving loopback flagged", msr_value[0], 1);
        clear_flag();

        // R6/R7: flow control, stop mid-character
        mcr_afc = 1'b1; tx_char_boundary = 1'b0;
        cts_n_pin = 1'b1; step(7);
        chk(tx_permit === 1'b1, "R6 no cut mid-character", tx_permit, 1);
        tx_char_boundary = 1'b1; step();
        chk(tx_permit === 1'b0, "R6 halt at boundary", tx_permit, 0);
        cts_n_pin = 1'b0; step(4);
        chk(tx_permit === 1'b1, "R7 resume when asserted", tx_permit, 1);
        cts_n_pin = 1'b1; step(6);
        chk(tx_permit === 1'b0, "R6 halt at boundary again", tx_permit, 0);
        mcr_afc = 1'b0; step();
        chk(tx_permit === 1'b1, "R7 afc off permits", tx_permit, 1);

        // randomized run, judged by the model each cycle
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 7) == 0) cts_n_pin = ~cts_n_pin;
            if ($urandom_range(0, 15) == 0) mcr_rts = ~mcr_rts;
            if ($urandom_range(0, 63) == 0) mcr_loop = ~mcr_loop;
            if ($urandom_range(0, 31) == 0) mcr_afc = ~mcr_afc;
            if ($urandom_range(0, 31) == 0) msi_enable = ~msi_enable;
            msr_read = ($urandom_range(0, 5) == 0);
            tx_char_boundary = ($urandom_range(0, 3) == 0);
            step();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule